// File: doc/BRIEF.md
# Converter Result Readout Slave (two-wire serial bus)

This block is the digital slave side of a small two-input 10-bit converter on a two-wire serial bus. A host writes single bytes to it to set the converter's operating fields. It reads the block back to collect the newest conversion result. The analog side presents each finished conversion on a parallel port with a one-cycle valid strobe. The block keeps the most recent value and serialises it as a two-byte pair whenever it is read.

Both bus lines are oversampled on the system clock through a short synchroniser chain. START and STOP conditions are found as data-line edges while the clock line is high. The slave never drives a line high: it pulls the data line low through an output-enable, and an external pull-up provides the high level. During a read the block keeps sending result pairs for as long as the host acknowledges each byte. Each pair takes a fresh copy of the newest result before its first byte.

Top module: `adc_i2c_readout`

## Requirements
- R1: After reset the scan field is 00, the channel bit is 0, the input-mode bit is 1 (single-ended), the clock-mode bit is 0, and the data line is released.
- R2: The slave pulls the data line low in the acknowledge slot of the address byte only when the upper seven bits equal the `SLAVE_ADDR` parameter. On a mismatch it leaves the line released until the next START, so no data byte is acknowledged and a read returns all ones.
- R3: The address byte's least significant bit selects the direction (1 = read, 0 = write). On a read each result is sent as two bytes, most significant bit first. The first byte is six ones followed by result bits 9:8, and the second byte is result bits 7:0.
- R4: After each read byte the slave samples the host's bit on the ninth clock rise. A low bit (acknowledge) makes it continue with the next byte of the stream. A high bit (not-acknowledge) makes it release the data line until the next START.
- R5: The result is copied from the newest sample only when a pair begins. A sample that arrives between the first and second byte of a pair does not change that pair's second byte, and the next pair carries the new sample.
- R6: A written byte with bit 7 = 0 updates the configuration fields: bits 6:5 go to the scan field, bit 1 to the channel bit and bit 0 to the input-mode bit. Bits 4:2 have no effect, and the clock-mode bit is kept.
- R7: A written byte with bit 7 = 1 updates the setup field: bit 3 goes to the clock-mode bit. The scan, channel and input-mode fields are kept.
- R8: The slave acknowledges every complete data byte written to it. A byte cut short by a STOP or START is discarded and changes no field.
- R9: A START or repeated START in any state restarts address reception, so a new address byte follows directly.
- R10: The slave changes the data-line enable only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| sda_oe | output | 1 | 1 pulls the data line low |
| smp_data | input | RES_W (10) | Newest conversion result |
| smp_valid | input | 1 | One-cycle strobe qualifying smp_data |
| cfg_scan | output | 2 | Scan-select field |
| cfg_chan | output | 1 | Channel-select bit |
| cfg_single | output | 1 | 1 = single-ended, 0 = differential |
| cfg_clk_mode | output | 1 | Conversion clock mode, 0 = internal |

## Verification
A wrong byte-phase state shows up on the bus within one bit period. It appears as an acknowledge that is missing or misplaced, or as a read byte that is shifted by one bit, and the scoreboard compares every read byte against a value computed from the samples it drove. A stale or torn result register shows up only in the second byte of a pair, so the bench changes the sample between the two bytes of a pair. A wrong field update becomes visible at the configuration outputs right after the acknowledge slot of the byte that caused it, and the bench checks those outputs after each write, after a mismatched address and after an aborted byte.

// File: rtl/adc_i2c_pkg.sv
// Shared types and field positions for the converter readout slave.
// Assumes written bytes are decoded by the fixed bit positions below.
package adc_i2c_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_AACK,
        ST_WR,
        ST_WACK,
        ST_RD,
        ST_RACK,
        ST_IGN
    } slv_state_t;

    // bit positions inside a written byte
    localparam int SEL_BIT  = 7;
    localparam int SCAN_HI  = 6;
    localparam int SCAN_LO  = 5;
    localparam int CLKM_BIT = 3;
    localparam int CHAN_BIT = 1;
    localparam int MODE_BIT = 0;

    // decoded fields of one complete written byte
    typedef struct packed {
        logic       sel;
        logic [1:0] scan;
        logic       clkm;
        logic       chan;
        logic       mode;
    } wr_fields_t;

endpackage

// File: rtl/adc_i2c_line_sync.sv
// Synchroniser and condition detector for the two bus lines.
// Assumes both lines idle high; outputs are one-cycle event pulses.
module adc_i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    logic [STAGES-1:0] scl_pipe;
    logic [STAGES-1:0] sda_pipe;
    logic              scl_prev;
    logic              sda_prev;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            // first flop of each chain takes the raw line
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[0] <= 1'b1;
                    sda_pipe[0] <= 1'b1;
                end else begin
                    scl_pipe[0] <= scl_in;
                    sda_pipe[0] <= sda_in;
                end
            end
        end else begin : g_next
            // later flops retime the previous stage
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[i] <= 1'b1;
                    sda_pipe[i] <= 1'b1;
                end else begin
                    scl_pipe[i] <= scl_pipe[i-1];
                    sda_pipe[i] <= sda_pipe[i-1];
                end
            end
        end
    end

    assign scl_s = scl_pipe[STAGES-1];
    assign sda_s = sda_pipe[STAGES-1];

    // previous synchronised levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;

endmodule

// File: rtl/adc_cfg_regs.sv
// Setup and configuration fields written over the bus.
// Assumes wr_stb pulses once per complete written byte.
module adc_cfg_regs
    import adc_i2c_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wr_stb,
    input  wr_fields_t wr_f,
    output logic [1:0] cfg_scan,
    output logic       cfg_chan,
    output logic       cfg_single,
    output logic       cfg_clk_mode
);

    // route each complete byte to the setup or configuration fields
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_scan     <= 2'b00;
            cfg_chan     <= 1'b0;
            cfg_single   <= 1'b1;
            cfg_clk_mode <= 1'b0;
        end else if (wr_stb) begin
            if (wr_f.sel) begin
                cfg_clk_mode <= wr_f.clkm;
            end else begin
                cfg_scan   <= wr_f.scan;
                cfg_chan   <= wr_f.chan;
                cfg_single <= wr_f.mode;
            end
        end
    end

    // R1
    reset_val_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cfg_scan == 2'b00 && !cfg_chan && cfg_single && !cfg_clk_mode));

    // R8
    no_stray_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_stb |=> $stable({cfg_scan, cfg_chan, cfg_single, cfg_clk_mode}));

    // R7
    setup_keeps_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && wr_f.sel) |=> $stable({cfg_scan, cfg_chan, cfg_single}));

    // R6
    cfg_keeps_setup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_stb && !wr_f.sel) |=> $stable(cfg_clk_mode));

endmodule

// File: rtl/adc_i2c_slave_fsm.sv
// Byte-level slave engine: address match, write decode, result streaming.
// Assumes synchronised lines and one-cycle edge/condition pulses; the
// data-line enable only moves on a clock-fall event.
module adc_i2c_slave_fsm
    import adc_i2c_pkg::*;
#(
    parameter logic [6:0] SLAVE_ADDR = 7'h36,
    parameter int         RES_W      = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic [RES_W-1:0] smp_data,
    input  logic             smp_valid,
    output logic             sda_oe,
    output logic             wr_stb,
    output wr_fields_t       wr_f
);

    localparam int PAD_W = 16 - RES_W;

    slv_state_t       state;
    logic [3:0]       bit_cnt;
    logic [7:0]       rx_q;
    logic [7:0]       tx_q;
    logic             rw_q;
    logic             nack_q;
    logic             lo_next;
    logic [RES_W-1:0] smp_q;
    logic [RES_W-1:0] cap_q;
    logic [7:0]       hi_new;

    // first byte of a fresh pair built from the newest sample
    always_comb hi_new = {{PAD_W{1'b1}}, smp_q[RES_W-1:8]};

    // hold the newest sample from the converter port
    always_ff @(posedge clk) begin
        if (!rst_n)         smp_q <= '0;
        else if (smp_valid) smp_q <= smp_data;
    end

    // byte state machine driven by bus events
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_cnt <= 4'd0;
            rx_q    <= 8'h00;
            tx_q    <= 8'h00;
            rw_q    <= 1'b0;
            nack_q  <= 1'b0;
            lo_next <= 1'b0;
            cap_q   <= '0;
            sda_oe  <= 1'b0;
            wr_stb  <= 1'b0;
            wr_f    <= '0;
        end else begin
            wr_stb <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= 4'd0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                state  <= ST_IDLE;
                sda_oe <= 1'b0;
            end else begin
                case (state)
                    ST_ADDR: begin
                        if (scl_rise) begin
                            rx_q    <= {rx_q[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (rx_q[7:1] == SLAVE_ADDR) begin
                                state  <= ST_AACK;
                                sda_oe <= 1'b1;
                                rw_q   <= rx_q[0];
                            end else begin
                                state <= ST_IGN;
                            end
                        end
                    end
                    ST_AACK: begin
                        if (scl_rise) begin
                            bit_cnt <= 4'd9;
                        end else if (scl_fall && bit_cnt == 4'd9) begin
                            bit_cnt <= 4'd0;
                            if (rw_q) begin
                                cap_q   <= smp_q;
                                tx_q    <= hi_new;
                                sda_oe  <= ~hi_new[7];
                                lo_next <= 1'b1;
                                state   <= ST_RD;
                            end else begin
                                sda_oe <= 1'b0;
                                state  <= ST_WR;
                            end
                        end
                    end
                    ST_WR: begin
                        if (scl_rise) begin
                            rx_q    <= {rx_q[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            wr_stb <= 1'b1;
                            wr_f   <= '{sel:  rx_q[SEL_BIT],
                                        scan: rx_q[SCAN_HI:SCAN_LO],
                                        clkm: rx_q[CLKM_BIT],
                                        chan: rx_q[CHAN_BIT],
                                        mode: rx_q[MODE_BIT]};
                            sda_oe <= 1'b1;
                            state  <= ST_WACK;
                        end
                    end
                    ST_WACK: begin
                        if (scl_rise) begin
                            bit_cnt <= 4'd9;
                        end else if (scl_fall && bit_cnt == 4'd9) begin
                            bit_cnt <= 4'd0;
                            sda_oe  <= 1'b0;
                            state   <= ST_WR;
                        end
                    end
                    ST_RD: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_RACK;
                        end else if (scl_fall && bit_cnt != 4'd0) begin
                            tx_q   <= {tx_q[6:0], 1'b0};
                            sda_oe <= ~tx_q[6];
                        end
                    end
                    ST_RACK: begin
                        if (scl_rise) begin
                            nack_q  <= sda_s;
                            bit_cnt <= 4'd9;
                        end else if (scl_fall && bit_cnt == 4'd9) begin
                            bit_cnt <= 4'd0;
                            if (nack_q) begin
                                state <= ST_IGN;
                            end else begin
                                state <= ST_RD;
                                if (lo_next) begin
                                    tx_q    <= cap_q[7:0];
                                    sda_oe  <= ~cap_q[7];
                                    lo_next <= 1'b0;
                                end else begin
                                    cap_q   <= smp_q;
                                    tx_q    <= hi_new;
                                    sda_oe  <= ~hi_new[7];
                                    lo_next <= 1'b1;
                                end
                            end
                        end
                    end
                    default: begin
                        sda_oe <= 1'b0;
                    end
                endcase
            end
        end
    end

    // R10
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> (!$past(scl_s) || $past(start_det || stop_det)));

    // R2
    ign_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IGN) |-> !sda_oe);

    // R5
    pair_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_RD) |=> $stable(cap_q));

    // R9
    start_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_det |=> (state == ST_ADDR && bit_cnt == 4'd0 && !sda_oe));

    // R8
    wr_stb_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ($past(state) == ST_WR && state == ST_WACK && sda_oe));

endmodule

// File: rtl/adc_i2c_readout.sv
// Top of the converter readout slave: line synchroniser, byte engine
// and field registers. Assumes an external pull-up on the data line.
module adc_i2c_readout #(
    parameter logic [6:0] SLAVE_ADDR  = 7'h36,
    parameter int         RES_W       = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    input  logic [RES_W-1:0] smp_data,
    input  logic             smp_valid,
    output logic [1:0]       cfg_scan,
    output logic             cfg_chan,
    output logic             cfg_single,
    output logic             cfg_clk_mode
);

    logic                    scl_s;
    logic                    sda_s;
    logic                    scl_rise;
    logic                    scl_fall;
    logic                    start_det;
    logic                    stop_det;
    logic                    wr_stb;
    adc_i2c_pkg::wr_fields_t wr_f;

    adc_i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    adc_i2c_slave_fsm #(.SLAVE_ADDR(SLAVE_ADDR), .RES_W(RES_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .smp_data  (smp_data),
        .smp_valid (smp_valid),
        .sda_oe    (sda_oe),
        .wr_stb    (wr_stb),
        .wr_f      (wr_f)
    );

    adc_cfg_regs u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_stb       (wr_stb),
        .wr_f         (wr_f),
        .cfg_scan     (cfg_scan),
        .cfg_chan     (cfg_chan),
        .cfg_single   (cfg_single),
        .cfg_clk_mode (cfg_clk_mode)
    );

endmodule

// File: tb/adc_i2c_readout_test.sv
`timescale 1ns/1ps
// Scoreboard bench: the bus driver queues expected read bytes, a
// monitor pops and compares each byte as it comes off the bus.
module adc_i2c_readout_test;

    localparam int Q     = 8;
    localparam int LIMIT = 100000;
    localparam logic [7:0] AW  = 8'h6C;   // address 0x36, write
    localparam logic [7:0] AR  = 8'h6D;   // address 0x36, read
    localparam logic [7:0] XW  = 8'hE0;   // foreign address, write
    localparam logic [7:0] XR  = 8'hE1;   // foreign address, read

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       sda_line;
    logic       sda_oe;
    logic [9:0] smp_data = '0;
    logic       smp_valid = 1'b0;
    logic [1:0] cfg_scan;
    logic       cfg_chan;
    logic       cfg_single;
    logic       cfg_clk_mode;

    int nchk = 0;
    int nerr = 0;
    int viol = 0;
    bit done = 1'b0;
    logic oe_prev = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];
    logic [7:0] got_byte;
    event       rd_ev;

    always #4 clk = ~clk;

    assign sda_line = sda_m & ~sda_oe;

    adc_i2c_readout uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .scl_in       (scl_m),
        .sda_in       (sda_line),
        .sda_oe       (sda_oe),
        .smp_data     (smp_data),
        .smp_valid    (smp_valid),
        .cfg_scan     (cfg_scan),
        .cfg_chan     (cfg_chan),
        .cfg_single   (cfg_single),
        .cfg_clk_mode (cfg_clk_mode)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wq();
        repeat (Q) @(negedge clk);
    endtask

    // one clock pulse, sampling the data line in the middle of the high phase
    task automatic pulse(output logic smp);
        wq();
        scl_m = 1'b1;
        wq();
        smp = sda_line;
        wq();
        scl_m = 1'b0;
        wq();
    endtask

    task automatic bus_start();
        sda_m = 1'b1;
        wq();
        scl_m = 1'b1;
        wq();
        sda_m = 1'b0;
        wq();
        scl_m = 1'b0;
        wq();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0;
        wq();
        scl_m = 1'b1;
        wq();
        sda_m = 1'b1;
        wq();
    endtask

    task automatic send_bits(input logic [7:0] b, input int n);
        logic s;
        for (int i = 7; i > 7 - n; i--) begin
            sda_m = b[i];
            pulse(s);
        end
    endtask

    // returns 0 when the slave acknowledged
    task automatic send_byte(input logic [7:0] b, output logic ack_n);
        send_bits(b, 8);
        sda_m = 1'b1;
        pulse(ack_n);
    endtask

    task automatic read_byte(input logic nack, input logic [7:0] exp, input string req);
        logic s;
        logic [7:0] v;
        v = '0;
        exp_q.push_back(exp);
        tag_q.push_back(req);
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            pulse(s);
            v = {v[6:0], s};
        end
        sda_m = nack;
        pulse(s);
        got_byte = v;
        ->rd_ev;
        #0;
    endtask

    task automatic push_sample(input logic [9:0] v);
        @(negedge clk);
        smp_data  = v;
        smp_valid = 1'b1;
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic chk_cfg(input logic [1:0] sc, input logic ch, input logic sg,
                           input logic ck, input string req);
        chk(cfg_scan == sc && cfg_chan == ch && cfg_single == sg && cfg_clk_mode == ck,
            req, {cfg_scan, cfg_chan, cfg_single, cfg_clk_mode}, {sc, ch, sg, ck});
    endtask

    // monitor: compare each read byte against the oldest expected item
    initial begin
        forever begin
            @(rd_ev);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R3", got_byte, 0);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(got_byte == e, t, got_byte, e);
            end
        end
    end

    // R10 watch: data-line enable must not move while the clock line is high
    always @(negedge clk) begin
        if (rst_n && sda_oe != oe_prev && scl_m) viol++;
        oe_prev = sda_oe;
    end

    initial begin
        repeat (LIMIT) @(posedge clk);
        if (!done) begin
            nchk++;
            nerr++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic a;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset values
        chk_cfg(2'b00, 1'b0, 1'b1, 1'b0, "R1");
        chk(sda_oe == 1'b0, "R1", sda_oe, 0);

        // R2 foreign address on a write: no acknowledge, no field change
        bus_start();
        send_byte(XW, a);
        chk(a == 1'b1, "R2", a, 1);
        send_byte(8'h00, a);
        chk(a == 1'b1, "R2", a, 1);
        bus_stop();
        chk_cfg(2'b00, 1'b0, 1'b1, 1'b0, "R2");

        // R6 configuration byte, don't-care bits 4:2 set
        bus_start();
        send_byte(AW, a);
        chk(a == 1'b0, "R2", a, 0);
        send_byte(8'b0101_1110, a);
        chk(a == 1'b0, "R8", a, 0);
        bus_stop();
        chk_cfg(2'b10, 1'b1, 1'b0, 1'b0, "R6");

        // R7 setup byte sets clock mode only
        bus_start();
        send_byte(AW, a);
        send_byte(8'b1000_1000, a);
        chk(a == 1'b0, "R8", a, 0);
        bus_stop();
        chk_cfg(2'b10, 1'b1, 1'b0, 1'b1, "R7");

        // R6 and R8 two bytes in one transaction, both acknowledged
        bus_start();
        send_byte(AW, a);
        send_byte(8'b1000_0000, a);
        chk(a == 1'b0, "R8", a, 0);
        send_byte(8'b0100_0011, a);
        chk(a == 1'b0, "R8", a, 0);
        bus_stop();
        chk_cfg(2'b10, 1'b1, 1'b1, 1'b0, "R6");

        // R8 partial byte cut by STOP is discarded
        bus_start();
        send_byte(AW, a);
        send_bits(8'b0000_0000, 4);
        bus_stop();
        chk_cfg(2'b10, 1'b1, 1'b1, 1'b0, "R8");

        // R3 R4 R5 streaming read, sample changes mid-pair
        push_sample(10'h2A5);
        bus_start();
        send_byte(AR, a);
        chk(a == 1'b0, "R2", a, 0);
        read_byte(1'b0, 8'hFE, "R3");
        push_sample(10'h133);
        read_byte(1'b0, 8'hA5, "R5");
        read_byte(1'b0, 8'hFD, "R4");
        read_byte(1'b1, 8'h33, "R5");
        repeat (4) @(negedge clk);
        chk(sda_oe == 1'b0, "R4", sda_oe, 0);
        bus_stop();

        // R9 repeated START in the middle of a written byte
        push_sample(10'h0C6);
        bus_start();
        send_byte(AW, a);
        send_bits(8'b0000_0000, 3);
        bus_start();
        send_byte(AR, a);
        chk(a == 1'b0, "R9", a, 0);
        read_byte(1'b0, 8'hFC, "R9");
        read_byte(1'b1, 8'hC6, "R3");
        bus_stop();
        chk_cfg(2'b10, 1'b1, 1'b1, 1'b0, "R8");

        // R2 foreign address on a read returns released line
        bus_start();
        send_byte(XR, a);
        chk(a == 1'b1, "R2", a, 1);
        read_byte(1'b1, 8'hFF, "R2");
        bus_stop();

        repeat (10) @(negedge clk);
        chk(exp_q.size() == 0, "R3", exp_q.size(), 0);
        chk(viol == 0, "R10", viol, 0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule